// File: doc/BRIEF.md
# Width-Adaptive Word Compactor

This block turns a 128-bit two's-complement operand into a compacted word made of 8-bit blocks. Leading blocks that only repeat the sign are dropped. A block is dropped when all of its bits equal the top bit of the block below it. Dropping works for both polarities, so small negative numbers shrink as well as small positive ones. Downstream logic then handles only the significant blocks. The block returns the kept blocks, how many there are, and a mask of the positions that are occupied.

Operands enter through a valid/ready handshake. The compacted result sits in one output register that holds its value under backpressure.

Two combinational helpers sit beside the compactor:
- The expander restores a full-width word from a compacted one by sign-extending the highest kept block.
- The growth checker takes two compacted operands and reports whether their sum needs one more block than the wider of the two.

Top module: `sbc_compactor`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: out_count is the smallest k in 1..16 for which sign-extending the low 8*k bits of the input reproduces the input exactly. 0 and -1 give 1, and the field is 5 bits wide.
- R3: Leading all-ones blocks are dropped just as leading all-zeros blocks are. For example, -128 (…FF80) gives 1 block, +128 (…0080) gives 2, and -129 (…FF7F) gives 2.
- R4: Kept block i appears on out_blocks[8*i+7:8*i], in its original position. Every dropped block position reads zero.
- R5: out_mask bit i is 1 exactly when i < out_count.
- R6: An input is accepted on a clock edge where in_valid and in_ready are both 1. Its result is shown with out_valid=1 after that edge.
- R7: While out_valid=1 and out_ready=0, in_ready is 0 and out_blocks, out_count and out_mask hold their values. When out_ready=1, in_ready is 1.
- R8: exp_word equals the low 8*c bits of exp_blocks, sign-extended to 128 bits, where c is exp_count. A count of 0 is treated as 1, and a count above 16 is treated as 16.
- R9: Expanding a compacted result (out_blocks, out_count) gives back the original input word exactly.
- R10: add_grow is 1 exactly when the signed sum of the two expanded operands does not fit in 8*w bits. Here w is the larger of the two clamped operand counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Compactor can take a word |
| in_word | input | 128 | Full-width operand |
| out_valid | output | 1 | Compacted result present |
| out_ready | input | 1 | Consumer takes the result |
| out_blocks | output | 128 | Kept blocks in place; dropped positions are zero |
| out_count | output | 5 | Number of kept blocks, 1..16 |
| out_mask | output | 16 | One bit per occupied block |
| exp_blocks | input | 128 | Compacted word to expand |
| exp_count | input | 5 | Block count of the word to expand |
| exp_word | output | 128 | Restored full-width word |
| add_a_blocks | input | 128 | First compacted addend |
| add_a_count | input | 5 | Block count of the first addend |
| add_b_blocks | input | 128 | Second compacted addend |
| add_b_count | input | 5 | Block count of the second addend |
| add_grow | output | 1 | Sum needs one more block |

## Verification
The compactor is tried with five groups of inputs:
- Zero and minus one, which must shrink to one block.
- Values on each side of every block boundary, in both polarities (+127/+128, -128/-129), which catch a sign-bit comparison that is off by one bit or ignores negative runs.
- The largest and smallest 128-bit values, which keep all sixteen blocks.
- Random values sign-extended from random widths, which cover every count.
- Full-width random words.

Each result is expanded again and compared with the input. Backpressure tests show that a held result does not change. Growth cases where a carry crosses a block boundary, and equal-width cases where it does not, show whether the overflow is judged at the right width.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    localparam int WORD_W = 128;
    localparam int BLK_W  = 8;
    localparam int NBLK   = WORD_W / BLK_W;
    localparam int CNT_W  = $clog2(NBLK + 1);

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [NBLK-1:0]  mask_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t blocks;
        cnt_t  count;
        mask_t mask;
    } cword_t;

    // Bring a block count into the legal range 1..NBLK.
    function automatic cnt_t clamp_count(input cnt_t c);
        if (c == '0)
            return cnt_t'(1);
        else if (int'(c) > NBLK)
            return cnt_t'(NBLK);
        else
            return c;
    endfunction

    // One mask bit for each occupied block position.
    function automatic mask_t count_to_mask(input cnt_t c);
        mask_t m;
        for (int i = 0; i < NBLK; i++)
            m[i] = (i < int'(c));
        return m;
    endfunction

    // Clear every block position that is not occupied.
    function automatic word_t keep_blocks(input word_t w, input mask_t m);
        word_t r;
        for (int i = 0; i < NBLK; i++)
            r[i*BLK_W +: BLK_W] = m[i] ? w[i*BLK_W +: BLK_W] : '0;
        return r;
    endfunction
endpackage

// File: rtl/sbc_width_detect.sv
module sbc_width_detect
    import sbc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  count
);
    // A block is significant when it differs from the sign bit of the block below it.
    // The count is one more than the index of the highest significant block.
    always_comb begin
        count = cnt_t'(1);
        for (int i = 1; i < NBLK; i++) begin
            if (word[i*BLK_W +: BLK_W] != {BLK_W{word[i*BLK_W-1]}})
                count = cnt_t'(i + 1);
        end
    end
endmodule

// File: rtl/sbc_expander.sv
module sbc_expander
    import sbc_pkg::*;
(
    input  logic [WORD_W-1:0] blocks,
    input  logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] word
);
    cnt_t c_eff;
    logic sgn;

    always_comb begin
        c_eff = clamp_count(count);
        sgn   = blocks[int'(c_eff)*BLK_W - 1];
        for (int j = 0; j < NBLK; j++)
            word[j*BLK_W +: BLK_W] = (j < int'(c_eff)) ? blocks[j*BLK_W +: BLK_W]
                                                       : {BLK_W{sgn}};
    end
endmodule

// File: rtl/sbc_growth_check.sv
module sbc_growth_check
    import sbc_pkg::*;
(
    input  logic [WORD_W-1:0] a_blocks,
    input  logic [CNT_W-1:0]  a_count,
    input  logic [WORD_W-1:0] b_blocks,
    input  logic [CNT_W-1:0]  b_count,
    output logic              grow
);
    localparam int SUM_W = WORD_W + 1;

    logic [WORD_W-1:0] a_full, b_full;
    logic signed [SUM_W-1:0] sum, upper;
    cnt_t ca, cb, w;

    sbc_expander u_exp_a (.blocks(a_blocks), .count(a_count), .word(a_full));
    sbc_expander u_exp_b (.blocks(b_blocks), .count(b_count), .word(b_full));

    // The sum fits in w blocks when every bit from the top bit of block w-1 upward is the same.
    always_comb begin
        ca    = clamp_count(a_count);
        cb    = clamp_count(b_count);
        w     = (ca > cb) ? ca : cb;
        sum   = $signed({a_full[WORD_W-1], a_full}) + $signed({b_full[WORD_W-1], b_full});
        upper = sum >>> (int'(w)*BLK_W - 1);
        grow  = !((upper == '0) || (&upper));
    end
endmodule

// File: rtl/sbc_compactor.sv
module sbc_compactor
    import sbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_blocks,
    output logic [CNT_W-1:0]  out_count,
    output logic [NBLK-1:0]   out_mask,
    input  logic [WORD_W-1:0] exp_blocks,
    input  logic [CNT_W-1:0]  exp_count,
    output logic [WORD_W-1:0] exp_word,
    input  logic [WORD_W-1:0] add_a_blocks,
    input  logic [CNT_W-1:0]  add_a_count,
    input  logic [WORD_W-1:0] add_b_blocks,
    input  logic [CNT_W-1:0]  add_b_count,
    output logic              add_grow
);
    cnt_t   det_count;
    cword_t next_c, held_c;
    logic   valid_q;

    sbc_width_detect u_detect (.word(in_word), .count(det_count));

    always_comb begin
        next_c.count  = det_count;
        next_c.mask   = count_to_mask(det_count);
        next_c.blocks = keep_blocks(in_word, next_c.mask);
    end

    assign in_ready = !valid_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            held_c  <= '0;
        end else if (in_valid && in_ready) begin
            valid_q <= 1'b1;
            held_c  <= next_c;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign out_valid  = valid_q;
    assign out_blocks = held_c.blocks;
    assign out_count  = held_c.count;
    assign out_mask   = held_c.mask;

    sbc_expander u_expand (.blocks(exp_blocks), .count(exp_count), .word(exp_word));

    sbc_growth_check u_growth (
        .a_blocks(add_a_blocks), .a_count(add_a_count),
        .b_blocks(add_b_blocks), .b_count(add_b_count),
        .grow(add_grow)
    );

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_count >= cnt_t'(1)) && (int'(out_count) <= NBLK)); // R2

    AST_MASK_POP: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_mask) == int'(out_count))); // R5

    AST_TOP_SIGNIF: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_count > cnt_t'(1)) |->
            (out_blocks[(int'(out_count)-1)*BLK_W +: BLK_W]
             != {BLK_W{out_blocks[(int'(out_count)-1)*BLK_W - 1]}})); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_blocks)
                                       && $stable(out_count) && $stable(out_mask))); // R7
endmodule

// File: tb/test_sbc_compactor.sv
module test_sbc_compactor;
    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid, in_ready, out_valid, out_ready;
    logic [127:0]  in_word, out_blocks, exp_blocks, exp_word, add_a_blocks, add_b_blocks;
    logic [4:0]    out_count, exp_count, add_a_count, add_b_count;
    logic [15:0]   out_mask;
    logic          add_grow;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    sbc_compactor i_sbc_compactor (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_blocks(out_blocks), .out_count(out_count), .out_mask(out_mask),
        .exp_blocks(exp_blocks), .exp_count(exp_count), .exp_word(exp_word),
        .add_a_blocks(add_a_blocks), .add_a_count(add_a_count),
        .add_b_blocks(add_b_blocks), .add_b_count(add_b_count),
        .add_grow(add_grow)
    );

    function automatic int ref_count(input logic [127:0] w);
        for (int k = 1; k <= 16; k++) begin
            logic signed [127:0] t;
            t = $signed(w << (128 - 8*k)) >>> (128 - 8*k);
            if (t == w) return k;
        end
        return 16;
    endfunction

    function automatic logic [127:0] ref_blocks(input logic [127:0] w, input int k);
        if (k >= 16) return w;
        return w & ((128'd1 << (8*k)) - 128'd1);
    endfunction

    function automatic logic [15:0] ref_mask(input int k);
        if (k >= 16) return 16'hFFFF;
        return (16'd1 << k) - 16'd1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_and_check(input logic [127:0] w);
        int k;
        k = ref_count(w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R6 valid", 128'(out_valid), 128'd1);
        chk(int'(out_count) == k, "R2/R3 count", 128'(out_count), 128'(k));
        chk(out_blocks == ref_blocks(w, k), "R4 blocks", out_blocks, ref_blocks(w, k));
        chk(out_mask == ref_mask(k), "R5 mask", 128'(out_mask), 128'(ref_mask(k)));
        exp_blocks = out_blocks;
        exp_count  = out_count;
        #1;
        chk(exp_word == w, "R9 round trip", exp_word, w);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; in_word = '0;
        exp_blocks = '0; exp_count = 5'd1;
        add_a_blocks = '0; add_a_count = 5'd1; add_b_blocks = '0; add_b_count = 5'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(out_valid == 1'b0, "R1 out_valid", 128'(out_valid), 128'd0);
        chk(in_ready == 1'b1, "R1 in_ready", 128'(in_ready), 128'd1);
    endtask

    task automatic t_corners;
        send_and_check(128'd0);
        send_and_check({128{1'b1}});
        send_and_check(128'd127);
        send_and_check(128'd128);                 // R3 positive boundary
        send_and_check(-128'sd128);               // R3 negative one block
        send_and_check(-128'sd129);               // R3 negative two blocks
        send_and_check(128'h7FFF);
        send_and_check(128'h8000);
        send_and_check({1'b0, {127{1'b1}}});      // maximum
        send_and_check({1'b1, 127'd0});           // minimum
        for (int b = 1; b < 16; b++) begin
            send_and_check(128'd1 << (8*b - 1));
            send_and_check(-(128'd1 << (8*b - 1)));
            send_and_check(-(128'd1 << (8*b - 1)) - 128'd1);
        end
    endtask

    task automatic t_random;
        for (int n = 0; n < 60; n++) begin
            logic [127:0] r;
            int sh;
            r  = {$urandom, $urandom, $urandom, $urandom};
            sh = $urandom_range(0, 127);
            send_and_check(128'($signed(r << sh) >>> sh));
        end
    endtask

    task automatic t_backpressure;
        logic [127:0] a, b;
        a = 128'h1234;
        b = -128'sd5;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_word   = a;
        @(negedge clk);
        chk(out_count == 5'd2, "R6 first accepted", 128'(out_count), 128'd2);
        in_word = b;
        chk(in_ready == 1'b0, "R7 in_ready low", 128'(in_ready), 128'd0);
        @(negedge clk);
        chk(out_blocks == a, "R7 held blocks", out_blocks, a);
        chk(out_count == 5'd2, "R7 held count", 128'(out_count), 128'd2);
        out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R7 in_ready high", 128'(in_ready), 128'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_count == 5'd1, "R6 second accepted", 128'(out_count), 128'd1);
        chk(out_blocks == 128'hFB, "R4 second blocks", out_blocks, 128'hFB);
    endtask

    task automatic t_expand_clamp;
        exp_blocks = 128'h80;
        exp_count  = 5'd0;
        #1;
        chk(exp_word == {{120{1'b1}}, 8'h80}, "R8 count zero", exp_word, {{120{1'b1}}, 8'h80});
        exp_blocks = 128'hA5A5_0000_0000_0000_0000_0000_0000_0000;
        exp_count  = 5'd31;
        #1;
        chk(exp_word == exp_blocks, "R8 count high", exp_word, exp_blocks);
        exp_blocks = 128'h7F_12;
        exp_count  = 5'd1;
        #1;
        chk(exp_word == 128'h12, "R8 upper ignored", exp_word, 128'h12);
    endtask

    task automatic grow_case(input logic [127:0] a, input logic [127:0] b);
        int ka, kb, w;
        logic signed [129:0] s, lim;
        bit g;
        ka = ref_count(a);
        kb = ref_count(b);
        w  = (ka > kb) ? ka : kb;
        s  = $signed({{2{a[127]}}, a}) + $signed({{2{b[127]}}, b});
        lim = 130'sd1 <<< (8*w - 1);
        g  = (s >= lim) || (s < -lim);
        add_a_blocks = ref_blocks(a, ka);
        add_a_count  = 5'(ka);
        add_b_blocks = ref_blocks(b, kb);
        add_b_count  = 5'(kb);
        #1;
        chk(add_grow == g, "R10 growth", 128'(add_grow), 128'(g));
    endtask

    task automatic t_growth;
        grow_case(128'd100, 128'd27);
        grow_case(128'd100, 128'd28);
        grow_case(-128'sd100, -128'sd28);
        grow_case(-128'sd100, -128'sd29);
        grow_case(128'h7FFF, 128'd1);
        grow_case(128'h7FFF, -128'sd1);
        grow_case({1'b0, {127{1'b1}}}, 128'd1);
        grow_case({1'b1, 127'd0}, {128{1'b1}});
        for (int n = 0; n < 30; n++) begin
            logic [127:0] ra, rb;
            int sa, sb;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            sa = $urandom_range(0, 127);
            sb = $urandom_range(0, 127);
            grow_case(128'($signed(ra << sa) >>> sa), 128'($signed(rb << sb) >>> sb));
        end
    endtask

    initial begin
        t_reset();
        t_corners();
        t_random();
        t_backpressure();
        t_expand_clamp();
        t_growth();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule